// File: doc/BRIEF.md
# Serial EEPROM Configuration Sequencer

This block moves configuration words between a bit-serial EEPROM and a small set of on-chip registers. A host starts a transfer by writing a 16-bit control register. One self-clearing start bit requests a reload (EEPROM to registers) and another requests a store (registers to EEPROM). A select bit picks the register group. With select high, only the general-purpose word is involved. With select low, a reload fills the configuration word, the base word and the three individual-address words, while a store writes back only the configuration and base words. A reload of that group also runs on its own as soon as reset is released.

While a transfer is running, the block shields the register file from the host. The control register reads back a fixed busy pattern, control writes are dropped, and write strobes to the other host registers are held off. Reloaded words reach the surrounding register file through one-hot write strobes. Store data is taken from that register file through an index-and-data read pair. The serial clock is derived from the system clock by a parameterised divider. Every stored word is sent as three steps: a write-enable command, then the write command, then a wait with chip select high until the device reports ready on its data-out line.

Top module: `eeprom_cfg_seq`

## Requirements
- R1: When reset is released, the block is busy and performs a reload with select low. Target index i (0 configuration, 1 base, 2..4 individual address) receives EEPROM word CFG_ADDR+i. The general-purpose target (index 5) is not written. The block then goes idle.
- R2: The control register layout is: bit 0 = store start, bit 1 = reload start, bit 2 = select, bits 15:3 = plain read/write storage. When idle, a read returns the last accepted bits 15:2 with bits 1:0 equal to 0.
- R3: Writing the control register with bit 1 set and bit 2 clear reloads targets 0..4 from words CFG_ADDR..CFG_ADDR+4. Each word arrives as a one-cycle pulse on tgt_we bit i together with tgt_wdata.
- R4: With bit 2 set, a reload writes only target 5 from word GP_ADDR, and a store writes only word GP_ADDR from target 5.
- R5: Writing bit 0 set (bit 1 clear, bit 2 clear) stores target 0 to word CFG_ADDR and target 1 to word CFG_ADDR+1. No other EEPROM word changes and no target is written.
- R6: From the clock edge that accepts a start until the transfer ends, ctl_rdata reads 16'h0003. After the transfer, bits 1:0 read 0.
- R7: While busy, control writes are ignored and reg_we_ok stays low. While idle, reg_we_ok follows host_reg_we.
- R8: The serial framing is as follows:
  - Read: a 1 start bit, opcode 10, a 6-bit address and then 16 data bits, all MSB first. Data is sampled at each rising edge of ee_sk.
  - Write-enable: start bit, opcode 00 and address 11xxxx.
  - Write: start bit, opcode 01, address and 16 data bits.
  - Frames are separated by chip select low. ee_sk pulses only while ee_cs is high, and ee_di is held while ee_sk is high.
- R9: If bits 0 and 1 are both written as 1, a reload is performed and no store takes place.
- R10: A reload completes within RELOAD_BUDGET clock cycles.
- R11: Each ee_sk period is 2*DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release starts a reload |
| ctl_we | input | 1 | Host write strobe for the control register |
| ctl_wdata | input | 16 | Host write data for the control register |
| ctl_rdata | output | 16 | Control register read value |
| host_reg_we | input | 1 | Host write strobe aimed at other registers |
| reg_we_ok | output | 1 | Gated version of host_reg_we |
| tgt_idx | output | 3 | Index of the target register being transferred |
| tgt_we | output | 6 | One-hot target write strobes for reloaded words |
| tgt_wdata | output | 16 | Data for the target write strobes |
| tgt_rdata | input | 16 | Current value of target tgt_idx, used by stores |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
A wrong sequencing state shows up at the ports as a wrong word in a target register or in the device memory. This becomes visible as soon as the operation's last strobe or write, a few hundred cycles after the start. A stuck state keeps ctl_rdata at 16'h0003 and reg_we_ok low indefinitely, so the bench's bounded wait catches it. A misaligned shift register or clock divider corrupts every transferred word or changes the measured ee_sk period on the first frame. Framing errors are also flagged by the device model as soon as chip select drops.

// File: rtl/eeprom_cfg_seq.sv
module eeprom_cfg_seq #(
  parameter int          DIV           = 2,
  parameter logic [5:0]  CFG_ADDR      = 6'h20,
  parameter logic [5:0]  GP_ADDR       = 6'h08,
  parameter int          RELOAD_BUDGET = 37500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [15:0] ctl_wdata,
  output logic [15:0] ctl_rdata,
  input  logic        host_reg_we,
  output logic        reg_we_ok,
  output logic [2:0]  tgt_idx,
  output logic [5:0]  tgt_we,
  output logic [15:0] tgt_wdata,
  input  logic [15:0] tgt_rdata,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);

  localparam int DW = $clog2(DIV + 1);
  localparam int FW = 25;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;
  typedef enum logic [2:0] {C_GO, C_RD, C_EW, C_WR, C_PD} cmd_t;

  st_t           st;
  cmd_t          cmd, lcmd;
  logic          is_store, sel, cs, sk;
  logic [2:0]    idx, nidx, last_idx;
  logic [12:0]   other;
  logic [DW-1:0] div_cnt;
  logic [FW-1:0] sh, lsh;
  logic [4:0]    last, llast, nbits;
  logic [15:0]   rx;
  logic [5:0]    we_r, waddr;
  logic          launch, to_poll, fin;

  wire busy     = (st != S_IDLE);
  wire tick     = (div_cnt == DW'(DIV - 1));
  wire gap_done = (st == S_GAP) && tick && nbits[0];

  assign last_idx  = sel ? 3'd5 : (is_store ? 3'd1 : 3'd4);
  assign waddr     = (nidx == 3'd5) ? GP_ADDR : CFG_ADDR + {3'b000, nidx};
  assign ctl_rdata = busy ? 16'h0003 : {other, sel, 2'b00};
  assign reg_we_ok = host_reg_we & ~busy;
  assign tgt_idx   = idx;
  assign tgt_we    = we_r;
  assign tgt_wdata = rx;
  assign ee_cs     = cs;
  assign ee_sk     = sk;
  assign ee_di     = sh[FW-1];

  always_comb begin
    launch  = 1'b0;
    to_poll = 1'b0;
    fin     = 1'b0;
    nidx    = idx;
    lcmd    = C_RD;
    case (cmd)
      C_GO: begin launch = 1'b1; lcmd = is_store ? C_EW : C_RD; end
      C_EW: begin launch = 1'b1; lcmd = C_WR; end
      C_WR: to_poll = 1'b1;
      default:
        if (idx == last_idx) fin = 1'b1;
        else begin
          launch = 1'b1;
          nidx   = idx + 3'd1;
          lcmd   = is_store ? C_EW : C_RD;
        end
    endcase
    case (lcmd)
      C_EW:    begin lsh = {3'b100, 6'b110000, 16'h0000}; llast = 5'd8;  end
      C_WR:    begin lsh = {3'b101, waddr, tgt_rdata};    llast = 5'd24; end
      default: begin lsh = {3'b110, waddr, 16'h0000};     llast = 5'd24; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP;  cmd <= C_GO;  is_store <= 1'b0;  sel <= 1'b0;
      idx <= 3'd0;  other <= '0;  cs <= 1'b0;  sk <= 1'b0;
      div_cnt <= '0;  sh <= '0;  last <= '0;  nbits <= '0;
      rx <= '0;  we_r <= '0;
    end else begin
      we_r    <= '0;
      div_cnt <= (st == S_IDLE || tick) ? '0 : div_cnt + 1'b1;
      case (st)
        S_IDLE:
          if (ctl_we) begin
            other <= ctl_wdata[15:3];
            sel   <= ctl_wdata[2];
            if (ctl_wdata[1] | ctl_wdata[0]) begin
              is_store <= ~ctl_wdata[1];
              idx      <= ctl_wdata[2] ? 3'd5 : 3'd0;
              cmd      <= C_GO;
              nbits    <= '0;
              st       <= S_GAP;
            end
          end
        S_SHIFT:
          if (tick) begin
            if (!sk) begin
              sk <= 1'b1;
              rx <= {rx[14:0], ee_do};
            end else begin
              sk <= 1'b0;
              if (nbits == last) begin
                cs    <= 1'b0;
                nbits <= '0;
                st    <= S_GAP;
                if (cmd == C_RD) we_r[idx] <= 1'b1;
              end else begin
                nbits <= nbits + 5'd1;
                sh    <= {sh[FW-2:0], 1'b0};
              end
            end
          end
        S_GAP:
          if (tick) begin
            nbits <= nbits + 5'd1;
            if (gap_done) begin
              if (launch) begin
                st <= S_SHIFT;  cs <= 1'b1;  sh <= lsh;  last <= llast;
                cmd <= lcmd;  idx <= nidx;  nbits <= '0;
              end else if (to_poll) begin
                st <= S_POLL;  cs <= 1'b1;
              end else if (fin) begin
                st <= S_IDLE;
              end
            end
          end
        default:
          if (tick && ee_do) begin
            cs <= 1'b0;  nbits <= '0;  cmd <= C_PD;  st <= S_GAP;
          end
      endcase
    end
  end

  logic [31:0] reload_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              reload_cyc <= '0;
    else if (st == S_IDLE)   reload_cyc <= '0;
    else if (!is_store)      reload_cyc <= reload_cyc + 32'd1;
  end

  AST_RELOAD_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    reload_cyc < 32'(RELOAD_BUDGET)); // R10
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_we)); // R3
  AST_WE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (tgt_we == 6'd0)); // R7
  AST_STORE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_store) |-> (tgt_we == 6'd0)); // R5
  AST_STORE_TARGETS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_store) |-> (idx == 3'd0 || idx == 3'd1 || idx == 3'd5)); // R5
  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R8
  AST_DI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R8

endmodule

// File: tb/test_eeprom_cfg_seq.sv
module test_eeprom_cfg_seq;
  localparam int         CLK_PERIOD = 10;
  localparam int         DIV        = 2;
  localparam logic [5:0] CFG        = 6'h20;
  localparam logic [5:0] GP         = 6'h08;
  localparam int         BUDGET     = 2 * DIV * 150;
  localparam logic [31:0] VEC [6] = '{32'h0002_1234, 32'h0001_ABCD, 32'h0006_4321,
                                       32'h0005_0F0F, 32'hF803_7777, 32'h8A02_0101};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, host_reg_we = 1'b0;
  logic [15:0] ctl_wdata = '0, ctl_rdata, tgt_wdata, tgt_rdata;
  logic reg_we_ok, ee_cs, ee_sk, ee_di, ee_do;
  logic [2:0] tgt_idx;
  logic [5:0] tgt_we;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  eeprom_cfg_seq #(.DIV(DIV), .CFG_ADDR(CFG), .GP_ADDR(GP), .RELOAD_BUDGET(BUDGET)) i_eeprom_cfg_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .host_reg_we(host_reg_we), .reg_we_ok(reg_we_ok), .tgt_idx(tgt_idx), .tgt_we(tgt_we),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] seed(input logic [5:0] a);
    return 16'h5A00 ^ (16'(a) * 16'h0293);
  endfunction

  // target register file
  logic [15:0] regs [6];
  logic [15:0] preset [6];
  logic        preset_go = 1'b0;
  always @(posedge clk)
    for (int i = 0; i < 6; i++)
      if (preset_go) regs[i] <= preset[i];
      else if (tgt_we[i]) regs[i] <= tgt_wdata;
  assign tgt_rdata = (tgt_idx < 3'd6) ? regs[tgt_idx] : 16'h0000;

  // behavioural serial EEPROM
  logic [15:0] mem [64];
  logic        init_go = 1'b0;
  logic [24:0] sr = '0;
  logic [5:0]  cnt = '0, wr_a = '0;
  logic [15:0] wr_d = '0, rd_sh = '0;
  logic        ewen = 1'b0, wr_tog = 1'b0, wr_seen = 1'b0, frame_err = 1'b0;
  logic        rd_active = 1'b0, rd_bit = 1'b0;
  int          wbusy = 0, sk_bad = 0, cyc = 0;

  always @(posedge ee_sk or negedge ee_cs)
    if (!ee_cs) begin
      if (cnt == 6'd9) begin
        if (sr[8:4] == 5'b10011) ewen <= 1'b1; else frame_err <= 1'b1;
      end else if (cnt == 6'd25) begin
        if (sr[24:22] == 3'b101) begin
          if (ewen) begin wr_a <= sr[21:16]; wr_d <= sr[15:0]; wr_tog <= ~wr_tog; end
          ewen <= 1'b0;
        end else if (sr[24:22] != 3'b110) frame_err <= 1'b1;
      end else if (cnt != 6'd0) frame_err <= 1'b1;
      cnt <= '0;
    end else begin
      sr  <= {sr[23:0], ee_di};
      cnt <= cnt + 6'd1;
    end

  always @(negedge ee_sk)
    if (cnt < 6'd9) rd_active <= 1'b0;
    else if (cnt == 6'd9 && sr[8:6] == 3'b110) begin
      rd_active <= 1'b1;
      rd_bit    <= mem[sr[5:0]][15];
      rd_sh     <= {mem[sr[5:0]][14:0], 1'b0};
    end else if (rd_active) begin
      rd_bit <= rd_sh[15];
      rd_sh  <= {rd_sh[14:0], 1'b0};
    end

  assign ee_do = (rd_active && ee_cs) ? rd_bit : (wbusy == 0 && wr_tog == wr_seen);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ee_sk && !ee_cs) sk_bad <= sk_bad + 1;
    if (init_go) begin
      for (int a = 0; a < 64; a++) mem[a] <= seed(6'(a));
      wr_seen <= wr_tog;
      wbusy   <= 0;
    end else if (wr_tog != wr_seen) begin
      wr_seen    <= wr_tog;
      mem[wr_a]  <= wr_d;
      wbusy      <= 40;
    end else if (wbusy != 0) wbusy <= wbusy - 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (ctl_rdata[1:0] != 2'b00 && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    if (cycles >= 20000) chk("R6 idle wait", 32'(ctl_rdata), 32'h0);
  endtask

  task automatic ctl_write(input logic [15:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  logic [15:0] emem [64];
  logic [15:0] eregs [6];

  initial begin
    int n, t0, t1, mism;
    string tag;
    for (int a = 0; a < 64; a++) emem[a] = seed(6'(a));
    for (int i = 0; i < 6; i++) preset[i] = 16'h1111 * 16'(i + 1);
    preset_go = 1'b1; init_go = 1'b1;
    repeat (4) @(negedge clk);
    preset_go = 1'b0; init_go = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 busy after reset", 32'(ctl_rdata), 32'h0003);
    wait_idle(n);
    chk("R10 reset reload time", 32'(n <= BUDGET), 32'h1);
    for (int i = 0; i < 5; i++) chk("R1 reset reload word", 32'(regs[i]), 32'(seed(CFG + 6'(i))));
    chk("R1 gp untouched", 32'(regs[5]), 32'(preset[5]));
    chk("R2 idle readback after reset", 32'(ctl_rdata), 32'h0);

    foreach (VEC[k]) begin
      logic [15:0] c;
      logic rel, sto;
      c   = VEC[k][31:16];
      rel = c[1];
      sto = c[0] && !c[1];
      tag = (c[1] && c[0]) ? "R9" : c[2] ? "R4" : rel ? "R3" : "R5";
      @(negedge clk);
      for (int i = 0; i < 6; i++) preset[i] = VEC[k][15:0] ^ (16'h0101 * 16'(i + 3));
      preset_go = 1'b1;
      @(negedge clk);
      preset_go = 1'b0;
      for (int i = 0; i < 6; i++) eregs[i] = preset[i];
      if (rel) begin
        if (c[2]) eregs[5] = emem[GP];
        else for (int i = 0; i < 5; i++) eregs[i] = emem[CFG + 6'(i)];
      end
      if (sto) begin
        if (c[2]) emem[GP] = preset[5];
        else begin emem[CFG] = preset[0]; emem[CFG + 6'd1] = preset[1]; end
      end
      ctl_write(c);
      chk({"R6 busy pattern ", tag}, 32'(ctl_rdata), 32'h0003);
      wait_idle(n);
      if (rel) chk("R10 reload time", 32'(n <= BUDGET), 32'h1);
      for (int i = 0; i < 6; i++) chk({tag, " target word"}, 32'(regs[i]), 32'(eregs[i]));
      mism = 0;
      for (int a = 0; a < 64; a++) if (mem[a] !== emem[a]) mism++;
      chk({tag, " eeprom contents"}, 32'(mism), 32'h0);
      chk("R2 control readback", 32'(ctl_rdata), 32'({c[15:2], 2'b00}));
    end

    // R7: gating while busy, ignored control write
    @(negedge clk);
    host_reg_we = 1'b1;
    #1 chk("R7 idle pass-through", 32'(reg_we_ok), 32'h1);
    host_reg_we = 1'b0;
    ctl_write(16'h0002);
    host_reg_we = 1'b1;
    #1 chk("R7 busy gate", 32'(reg_we_ok), 32'h0);
    host_reg_we = 1'b0;
    ctl_write(16'hFFFD);
    wait_idle(n);
    chk("R7 ignored busy write", 32'(ctl_rdata), 32'h0000);
    repeat (60) @(negedge clk);
    chk("R7 no late start", 32'({ee_cs, ctl_rdata}), 32'h0);

    // R11: serial clock period
    ctl_write(16'h0006);
    @(posedge ee_sk); t0 = cyc;
    @(posedge ee_sk); t1 = cyc;
    chk("R11 sk period", 32'(t1 - t0), 32'(2 * DIV));
    wait_idle(n);

    chk("R8 framing errors", 32'(frame_err), 32'h0);
    chk("R8 sk without cs", 32'(sk_bad), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule